// File: doc/BRIEF.md
# Line-rate NMI and sync generator

This block replaces the line-timing part of a video front end in a small CPU system. A free-running counter, clocked by the CPU clock, divides time into fixed scan-line periods. In every period it drives two active-low pulses. The first is a horizontal sync pulse that is always present. The second is a non-maskable interrupt (NMI) pulse that is narrower, starts a few clocks after the sync pulse, and is only produced while software has enabled it.

Software turns the interrupt stream on and off with I/O writes. A write with address bit 0 low enables the stream, and a write with address bit 1 low disables it. A wait-request output stalls a running CPU for the length of each interrupt pulse, so that the CPU always takes the interrupt from the same machine state.

A change of enable state is only applied at a period boundary. An interrupt pulse is therefore never cut short, and the counter phase never moves.

Top module: `nmi_sync_gen`

## Requirements
- R1: The line counter runs freely from 0 to PERIOD-1 (default 207) and wraps. Falling edges of `sync_n` are exactly PERIOD clocks apart.
- R2: `sync_n` is low for exactly SYNC_W clocks (default 20) in every period, whether the interrupt stream is enabled or not.
- R3: While the stream is active, `nmi_n` is low for exactly NMI_W clocks (default 16) in every period.
- R4: `nmi_n` falls exactly LEAD clocks (default 3) after `sync_n` falls.
- R5: A clock edge with `iowr_n` low, `a0` low and `a1` high sets the enable latch. A clock edge with `iowr_n` low and `a1` low clears it, and clearing wins when both address bits are low. With `iowr_n` high the address bits are ignored. `nmi_enabled` shows the latch one clock after the write.
- R6: A change of the enable latch reaches the interrupt gate only on the clock edge at which the counter wraps. An interrupt pulse that has started always runs to its full width.
- R7: While the gate is closed, `nmi_n` stays high and the sync stream keeps its phase and width.
- R8: `wait_n` is low exactly when `nmi_n` is low and `halt_n` was high at the same clock edge.
- R9: Synchronous reset (`rst_n` low) holds all pulse outputs high and clears the enable state. The first sync pulse starts at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iowr_n | input | 1 | Active-low I/O write strobe |
| a0 | input | 1 | Address bit 0; low selects the enable port |
| a1 | input | 1 | Address bit 1; low selects the disable port |
| halt_n | input | 1 | Active-low CPU halt status |
| sync_n | output | 1 | Active-low horizontal sync pulse |
| nmi_n | output | 1 | Active-low non-maskable interrupt pulse |
| wait_n | output | 1 | Active-low wait request to the CPU |
| nmi_enabled | output | 1 | Current state of the enable latch |

## Verification
The two functions that can collide are the enable and disable writes and the period-boundary transfer that opens or closes the interrupt gate. A write can land in the very clock where the counter wraps, or in the middle of a running interrupt pulse. Directed writes placed inside an interrupt pulse and right at the wrap are mixed with random writes, random address bits and random halt levels. A reference cycle model in the bench predicts every output on every clock. Separately measured edge spacings confirm that no pulse is shortened, added or shifted in phase.

// File: rtl/nsg_pkg.sv
// Package: shared types and helpers for the line-rate NMI and sync generator.
// Assumes counter values fit in 32 bits.
package nsg_pkg;

    // Decoded meaning of one I/O write cycle
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_ON   = 2'd1,
        CMD_OFF  = 2'd2
    } port_cmd_e;

    // Decode strobe and address bits; the disable port wins when both selects are low
    function automatic port_cmd_e decode_port(input logic wr_n, input logic sel_on_n,
                                              input logic sel_off_n);
        if (wr_n)
            return CMD_NONE;
        if (!sel_off_n)
            return CMD_OFF;
        if (!sel_on_n)
            return CMD_ON;
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/nsg_line_timer.sv
// Module: free-running line counter.
// Counts 0..PERIOD-1 and wraps; flags the last count of each period.
// Assumes PERIOD >= 2.
module nsg_line_timer #(
    parameter int PERIOD = 207,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    // Last count of the period: the next edge is the boundary
    assign wrap = (cnt == LAST);

    // Advance the counter, wrapping at the period end
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wrap)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);                                                      // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)));                   // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LAST) |=> (cnt == '0));                                    // R1
endmodule

// File: rtl/nsg_port_latch.sv
// Module: I/O-port decoded enable latch plus the boundary-aligned gate.
// The requested state follows writes at once. The applied state copies it only
// when the counter wraps, so an interrupt pulse is never cut short.
module nsg_port_latch
    import nsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic iowr_n,
    input  logic a0,
    input  logic a1,
    input  logic wrap,
    output logic en_req,
    output logic en_act
);
    port_cmd_e cmd;

    // Decode the current bus cycle
    assign cmd = decode_port(iowr_n, a0, a1);

    // Requested enable state, set and cleared by port writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_req <= 1'b0;
        else if (cmd == CMD_ON)
            en_req <= 1'b1;
        else if (cmd == CMD_OFF)
            en_req <= 1'b0;
    end

    // Applied gate, updated only at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_act <= 1'b0;
        else if (wrap)
            en_act <= en_req;
    end

    AST_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!iowr_n && !a1) |=> !en_req);                                     // R5
    AST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!iowr_n && !a0 && a1) |=> en_req);                                // R5
    AST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        iowr_n |=> $stable(en_req));                                       // R5
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(en_act));                                        // R6
endmodule

// File: rtl/nsg_pulse_gen.sv
// Module: registered pulse shaper.
// Builds the sync window, the gated interrupt window and the wait request from
// the counter value, and registers all three so the outputs are free of glitches.
// Assumes LEAD + NMI_W <= PERIOD and SYNC_W < PERIOD.
module nsg_pulse_gen #(
    parameter int PERIOD = 207,
    parameter int SYNC_W = 20,
    parameter int NMI_W  = 16,
    parameter int LEAD   = 3,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          en_act,
    input  logic          halt_n,
    output logic          sync_n,
    output logic          nmi_n,
    output logic          wait_n
);
    localparam logic [CW-1:0] SYNC_END = CW'(SYNC_W);
    localparam logic [CW-1:0] NMI_BEG  = CW'(LEAD);
    localparam logic [CW-1:0] NMI_END  = CW'(LEAD + NMI_W);

    logic sync_win;
    logic nmi_win;
    logic nmi_fire;

    // The sync window opens at count 0
    assign sync_win = (cnt < SYNC_END);

    // The interrupt window is placed by the lead offset; a zero lead needs no lower bound
    generate
        if (LEAD == 0) begin : g_nmi_at_zero
            assign nmi_win = (cnt < NMI_END);
        end else begin : g_nmi_offset
            assign nmi_win = (cnt >= NMI_BEG) && (cnt < NMI_END);
        end
    endgenerate

    // The interrupt fires only while the applied gate is open
    assign nmi_fire = nmi_win && en_act;

    // Register the active-low outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_n <= 1'b1;
            nmi_n  <= 1'b1;
            wait_n <= 1'b1;
        end else begin
            sync_n <= !sync_win;
            nmi_n  <= !nmi_fire;
            wait_n <= !(nmi_fire && halt_n);
        end
    end

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_act |=> nmi_n);                                                // R7
    AST_SYNC_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> !sync_n);                                          // R2
endmodule

// File: rtl/nmi_sync_gen.sv
// Module: top of the line-rate NMI and sync generator.
// Connects the line timer, the port latch and the pulse shaper. Also holds the
// pulse-length counters that the width and offset assertions use.
module nmi_sync_gen #(
    parameter int PERIOD = 207,
    parameter int SYNC_W = 20,
    parameter int NMI_W  = 16,
    parameter int LEAD   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic iowr_n,
    input  logic a0,
    input  logic a1,
    input  logic halt_n,
    output logic sync_n,
    output logic nmi_n,
    output logic wait_n,
    output logic nmi_enabled
);
    localparam int CW = $clog2(PERIOD);
    localparam logic [CW-1:0] LEN_MAX = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;
    logic          wrap;
    logic          en_req;
    logic          en_act;
    logic [CW-1:0] sync_len;
    logic [CW-1:0] nmi_len;

    nsg_line_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .wrap  (wrap)
    );

    nsg_port_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .iowr_n (iowr_n),
        .a0     (a0),
        .a1     (a1),
        .wrap   (wrap),
        .en_req (en_req),
        .en_act (en_act)
    );

    nsg_pulse_gen #(
        .PERIOD (PERIOD),
        .SYNC_W (SYNC_W),
        .NMI_W  (NMI_W),
        .LEAD   (LEAD)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt    (cnt),
        .en_act (en_act),
        .halt_n (halt_n),
        .sync_n (sync_n),
        .nmi_n  (nmi_n),
        .wait_n (wait_n)
    );

    assign nmi_enabled = en_req;

    // Count how long each output has been low, saturating at the period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_len <= '0;
            nmi_len  <= '0;
        end else begin
            sync_len <= sync_n ? '0 : ((sync_len == LEN_MAX) ? sync_len : sync_len + CW'(1));
            nmi_len  <= nmi_n  ? '0 : ((nmi_len  == LEN_MAX) ? nmi_len  : nmi_len  + CW'(1));
        end
    end

    AST_SYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> (sync_len == CW'(SYNC_W)));                      // R2
    AST_NMI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_n) |-> (nmi_len == CW'(NMI_W)));                         // R3
    AST_NMI_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nmi_n) |-> (sync_len == CW'(LEAD)));                         // R4
    AST_WAIT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        wait_n == !($past(halt_n) && !nmi_n));                             // R8
endmodule

// File: tb/sim_nmi_sync_gen.sv
// Bench: a cycle model built from the requirements, plus separately measured
// pulse edges. Random writes, address bits and halt levels use a fixed seed and
// are mixed with directed corner cases.
module sim_nmi_sync_gen;
    localparam int P  = 207;
    localparam int SW = 20;
    localparam int NW = 16;
    localparam int LD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iowr_n = 1'b1;
    logic a0 = 1'b1;
    logic a1 = 1'b1;
    logic halt_n = 1'b1;
    logic sync_n, nmi_n, wait_n, nmi_enabled;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    nmi_sync_gen u0 (
        .clk(clk), .rst_n(rst_n), .iowr_n(iowr_n), .a0(a0), .a1(a1), .halt_n(halt_n),
        .sync_n(sync_n), .nmi_n(nmi_n), .wait_n(wait_n), .nmi_enabled(nmi_enabled)
    );

    // Reference model state
    int m_cnt = 0;
    bit m_req = 0, m_act = 0, m_sync = 1, m_nmi = 1, m_wait = 1;

    function automatic bit in_nmi_win(int c);
        return (c >= LD) && (c < LD + NW);
    endfunction

    // Next requested enable state, from R5
    function automatic bit next_req(bit req, logic wr_n, logic s0, logic s1);
        if (wr_n) return req;
        if (!s1) return 1'b0;
        if (!s0) return 1'b1;
        return req;
    endfunction

    // Model update on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0; m_req <= 0; m_act <= 0;
            m_sync <= 1; m_nmi <= 1; m_wait <= 1;
        end else begin
            m_sync <= !(m_cnt < SW);
            m_nmi  <= !(m_act && in_nmi_win(m_cnt));
            m_wait <= !(m_act && in_nmi_win(m_cnt) && halt_n);
            m_act  <= (m_cnt == P - 1) ? m_req : m_act;
            m_req  <= next_req(m_req, iowr_n, a0, a1);
            m_cnt  <= (m_cnt == P - 1) ? 0 : m_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Per-cycle comparison and edge measurement, away from the rising edge
    int ncyc = 0;
    int last_sfall = -1;
    int last_nfall = -1;
    bit p_sync = 1, p_nmi = 1;
    always @(negedge clk) begin
        if (live) begin
            ncyc++;
            chk(sync_n == m_sync, "R2 sync_n level", sync_n, m_sync);
            chk(nmi_n == m_nmi, "R3 R6 R7 nmi_n level", nmi_n, m_nmi);
            chk(wait_n == m_wait, "R8 wait_n level", wait_n, m_wait);
            chk(nmi_enabled == m_req, "R5 nmi_enabled", nmi_enabled, m_req);
            if (p_sync && !sync_n) begin
                if (last_sfall >= 0)
                    chk(ncyc - last_sfall == P, "R1 sync period", ncyc - last_sfall, P);
                last_sfall = ncyc;
            end
            if (!p_sync && sync_n)
                chk(ncyc - last_sfall == SW, "R2 sync width", ncyc - last_sfall, SW);
            if (p_nmi && !nmi_n) begin
                chk(ncyc - last_sfall == LD, "R4 nmi lead", ncyc - last_sfall, LD);
                last_nfall = ncyc;
            end
            if (!p_nmi && nmi_n)
                chk(ncyc - last_nfall == NW, "R3 R6 nmi width", ncyc - last_nfall, NW);
            p_sync = sync_n;
            p_nmi = nmi_n;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic s0, input logic s1);
        @(negedge clk);
        iowr_n = 1'b0; a0 = s0; a1 = s1;
        @(negedge clk);
        iowr_n = 1'b1; a0 = 1'b1; a1 = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin : main
        int seed;
        int r;
        seed = 1234;
        r = $urandom(seed);
        // R9: reset holds outputs inactive
        idle(3);
        chk(sync_n && nmi_n && wait_n, "R9 outputs high in reset", {sync_n, nmi_n, wait_n}, 7);
        chk(nmi_enabled == 1'b0, "R9 enable cleared", nmi_enabled, 0);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);
        chk(sync_n == 1'b0, "R9 first sync after release", sync_n, 0);
        // R5: strobe high with enable address is ignored
        @(negedge clk);
        iowr_n = 1'b1; a0 = 1'b0; a1 = 1'b1;
        idle(3);
        a0 = 1'b1;
        chk(nmi_enabled == 1'b0, "R5 no strobe no change", nmi_enabled, 0);
        // R6/R7: enable inside the first period, gate stays closed until the wrap
        wr(1'b0, 1'b1);
        chk(nmi_enabled == 1'b1, "R5 enable write", nmi_enabled, 1);
        chk(nmi_n == 1'b1, "R6 R7 no pulse before boundary", nmi_n, 1);
        // Align to an interrupt pulse of a later period, then disable mid-pulse
        idle(P + 8 - ncyc % P);
        chk(nmi_n == 1'b0, "R3 pulse running", nmi_n, 0);
        wr(1'b1, 1'b0);
        chk(nmi_n == 1'b0, "R6 pulse not truncated", nmi_n, 0);
        // R5: both selects low -> disable wins
        wr(1'b0, 1'b1);
        wr(1'b0, 1'b0);
        chk(nmi_enabled == 1'b0, "R5 both low disables", nmi_enabled, 0);
        // Write landing at the wrap cycle
        idle(P - 1 - ncyc % P);
        wr(1'b0, 1'b1);
        idle(2 * P);
        // Random mix
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            r = $urandom;
            halt_n = (r[2:0] != 3'd0);
            iowr_n = (r[8:3] != 6'd0);
            a0 = r[9];
            a1 = r[10];
        end
        iowr_n = 1'b1;
        idle(P);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule